// File: doc/BRIEF.md
# Timer with Selectable Fixed Wrap Value

A 16-bit up-counter that advances once on each cycle where an external, already prescaled, count enable is high. A two-bit field in a mode register picks the wrap point. One code turns the fixed wrap value off, so the counter runs over the full 16-bit range. The other three codes select one of three wrap values, each a power of two minus one. The counter returns to zero on the enabled count that follows the selected value, and that wrap sets an overflow flag.

A compare flag is set when the counter matches an input compare value on an enabled cycle. Each flag stays set until its own clear strobe arrives. Each flag also has a mask bit. An interrupt request is raised only while the flag, its mask and a global interrupt enable are all high.

The block sits beside a bus interface that owns the registers' addressing. Clock source selection is done upstream and reaches this block only as the count enable.

Top module: `tmr_fixtop`

## Requirements
- R1: After the asynchronous reset (rst_ni low), count_o is 0, both flags are 0, both mask bits are 0 and the wrap select is 00 (full range).
- R2: count_o increments by one only at a clock edge where cnt_en_i is high. With cnt_en_i low, count_o holds its value.
- R3: On a write, the wrap select is taken from mode_wdata_i[7:6]. The codes are: 00 gives full range (0xFFFF to 0), 01 gives 0x00FF, 10 gives 0x01FF and 11 gives 0x03FF. The enabled count after the selected value gives 0. Bits 5:0 of the mode write have no effect on counting.
- R4: ovf_flag_o is set by the enabled count on which the counter wraps to 0, and is visible one cycle later.
- R5: If a newly selected wrap value is below the current count, the counter keeps counting up to 0xFFFF and wraps to 0. After that it obeys the new wrap value.
- R6: cmp_flag_o is set by an enabled count at which count_o equals cmp_val_i, and is visible the next cycle.
- R7: A flag stays set until its clear strobe (clr_cmp_i or clr_ovf_i) is high at a clock edge. A clear in the same cycle as a set event leaves the flag set.
- R8: mask_wdata_i bit 1 is the compare mask and bit 0 is the overflow mask. Both are loaded when mask_we_i is high.
- R9: irq_cmp_o is high exactly when cmp_flag_o, the compare mask and gie_i are all high.
- R10: irq_ovf_o is high exactly when ovf_flag_o, the overflow mask and gie_i are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Prescaled count enable |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode write data; bits 7:6 are the wrap select |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data; bit 1 is the compare mask, bit 0 is the overflow mask |
| gie_i | input | 1 | Global interrupt enable |
| cmp_val_i | input | 16 | Compare value |
| clr_cmp_i | input | 1 | Compare flag clear strobe |
| clr_ovf_i | input | 1 | Overflow flag clear strobe |
| count_o | output | 16 | Counter value |
| cmp_flag_o | output | 1 | Compare flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
A compare match and a clear of the compare flag can fall in the same cycle. The bench parks the counter on the compare value, then raises cnt_en_i and clr_cmp_i together for one edge. The flag must read 1 afterwards, and a later clear on its own must drop it to 0. A second overlap comes from changing the wrap select while the counter sits above the new wrap value. Here the bench expects no early wrap and expects exactly one overflow at the 16-bit boundary.

// File: rtl/tmr_fixtop_pkg.sv
package tmr_fixtop_pkg;
  typedef enum logic [1:0] {
    TOP_FULL = 2'b00,
    TOP_W8   = 2'b01,
    TOP_W9   = 2'b10,
    TOP_W10  = 2'b11
  } top_sel_e;

  localparam int unsigned MODE_TOP_HI  = 7;
  localparam int unsigned MODE_TOP_LO  = 6;
  localparam int unsigned MASK_CMP_BIT = 1;
  localparam int unsigned MASK_OVF_BIT = 0;
  localparam int unsigned NUM_FLAGS    = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_fixtop_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TOP_BASE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  top_sel_e         top_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, top_val;
  logic             at_wrap;

  // fixed wrap = 2^(TOP_BASE_W-1+code)-1
  always_comb begin
    top_val = '1;
    if (top_sel_i != TOP_FULL)
      top_val = CNT_W'((33'd1 << (TOP_BASE_W - 1 + int'(top_sel_i))) - 33'd1);
  end

  // equality only: a count above a new top runs on to the full wrap
  assign at_wrap = (cnt_q == top_val) || (cnt_q == '1);
  assign wrap_o  = en_i && at_wrap;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  assert_full_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i & gie_i;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/tmr_fixtop.sv
module tmr_fixtop
  import tmr_fixtop_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TOP_BASE_W = 8,
  parameter int unsigned REG_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             mode_we_i,
  input  logic [REG_W-1:0] mode_wdata_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] mask_wdata_i,
  input  logic             gie_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             clr_cmp_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o,
  output logic             irq_cmp_o,
  output logic             irq_ovf_o
);
  top_sel_e               top_sel_q;
  logic [NUM_FLAGS-1:0]   mask_q, set_vec, clr_vec, flag_vec, irq_vec;
  logic                   wrap;
  logic                   unused_wdata;

  assign unused_wdata = ^{mode_wdata_i, mask_wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_sel_q <= TOP_FULL;
      mask_q    <= '0;
    end else begin
      if (mode_we_i) top_sel_q <= top_sel_e'(mode_wdata_i[MODE_TOP_HI:MODE_TOP_LO]);
      if (mask_we_i) mask_q    <= mask_wdata_i[NUM_FLAGS-1:0];
    end
  end

  tmr_counter #(.CNT_W(CNT_W), .TOP_BASE_W(TOP_BASE_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .top_sel_i (top_sel_q),
    .cnt_o     (count_o),
    .wrap_o    (wrap)
  );

  // flag index matches mask bit position
  assign set_vec[MASK_CMP_BIT] = cnt_en_i && (count_o == cmp_val_i);
  assign set_vec[MASK_OVF_BIT] = wrap;
  assign clr_vec[MASK_CMP_BIT] = clr_cmp_i;
  assign clr_vec[MASK_OVF_BIT] = clr_ovf_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tmr_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .mask_i (mask_q[g]),
      .gie_i  (gie_i),
      .flag_o (flag_vec[g]),
      .irq_o  (irq_vec[g])
    );
  end

  assign cmp_flag_o = flag_vec[MASK_CMP_BIT];
  assign ovf_flag_o = flag_vec[MASK_OVF_BIT];
  assign irq_cmp_o  = irq_vec[MASK_CMP_BIT];
  assign irq_ovf_o  = irq_vec[MASK_OVF_BIT];

  assert_cmp_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && count_o == cmp_val_i) |=> cmp_flag_o);
  assert_irq_cmp_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cmp_o |-> (cmp_flag_o && gie_i));
  assert_irq_ovf_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovf_o |-> (ovf_flag_o && gie_i));
  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: tb/tmr_fixtop_bench.sv
`timescale 1ns/1ps
module tmr_fixtop_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cnt_en_i = 0, mode_we_i = 0, mask_we_i = 0, gie_i = 0;
  logic        clr_cmp_i = 0, clr_ovf_i = 0;
  logic [7:0]  mode_wdata_i = '0, mask_wdata_i = '0;
  logic [15:0] cmp_val_i = 16'hFFFF;
  logic [15:0] count_o;
  logic        cmp_flag_o, ovf_flag_o, irq_cmp_o, irq_ovf_o;
  int checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  tmr_fixtop u_tmr_fixtop (.*);

  // {sel[1:0], pulses[16:0], exp_count[15:0], exp_ovf}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 17'd255,   16'd255, 1'b0},  // R3 8-bit top
    {2'd1, 17'd1,     16'd0,   1'b1},  // R3 R4
    {2'd2, 17'd511,   16'd511, 1'b0},
    {2'd2, 17'd1,     16'd0,   1'b1},
    {2'd3, 17'd1024,  16'd0,   1'b1},  // 10-bit top
    {2'd3, 17'd600,   16'd600, 1'b0},
    {2'd1, 17'd10,    16'd610, 1'b0},  // R5 above new top
    {2'd1, 17'd64926, 16'd0,   1'b1},  // R5 full wrap
    {2'd1, 17'd256,   16'd0,   1'b1},  // R5 top now honoured
    {2'd0, 17'd300,   16'd300, 1'b0}   // full range
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic pulses(input int n);
    @(negedge clk_i); cnt_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cnt_en_i = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] d);
    @(negedge clk_i); mode_we_i = 1'b1; mode_wdata_i = d;
    @(negedge clk_i); mode_we_i = 1'b0;
  endtask

  task automatic wr_mask(input logic [7:0] d);
    @(negedge clk_i); mask_we_i = 1'b1; mask_wdata_i = d;
    @(negedge clk_i); mask_we_i = 1'b0;
  endtask

  task automatic clr(input logic c, input logic o);
    @(negedge clk_i); clr_cmp_i = c; clr_ovf_i = o;
    @(negedge clk_i); clr_cmp_i = 1'b0; clr_ovf_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    check("R1 count", count_o, 0);
    check("R1 flags", {cmp_flag_o, ovf_flag_o}, 0);
    check("R1 irqs", {irq_cmp_o, irq_ovf_o}, 0);

    for (int i = 0; i < NV; i++) begin
      clr(1'b0, 1'b1);
      wr_mode({VEC[i][35:34], 6'b0});
      pulses(int'(VEC[i][33:17]));
      check($sformatf("R3 vec%0d count", i), count_o, VEC[i][16:1]);
      check($sformatf("R4 vec%0d ovf", i), ovf_flag_o, VEC[i][0]);
    end

    // compare
    do_reset();
    cmp_val_i = 16'd5; gie_i = 1'b1;
    pulses(5);
    check("R6 no early cmp", cmp_flag_o, 0);
    check("R2 count 5", count_o, 5);
    pulses(1);
    check("R6 cmp set", cmp_flag_o, 1);
    check("R9 masked irq", irq_cmp_o, 0);
    clr(1'b1, 1'b0);
    check("R7 clear", cmp_flag_o, 0);
    // clear coinciding with set
    cmp_val_i = 16'd6;
    @(negedge clk_i); cnt_en_i = 1'b1; clr_cmp_i = 1'b1;
    @(negedge clk_i); cnt_en_i = 1'b0; clr_cmp_i = 1'b0;
    check("R7 set beats clear", cmp_flag_o, 1);
    check("R2 count 7", count_o, 7);
    pulses(3);
    check("R7 sticky", cmp_flag_o, 1);
    gie_i = 1'b0;
    wr_mask(8'h02);
    check("R9 gie off", irq_cmp_o, 0);
    gie_i = 1'b1;
    @(negedge clk_i);
    check("R9 irq on", irq_cmp_o, 1);
    wr_mask(8'h01);
    check("R8 bit1 is cmp mask", irq_cmp_o, 0);
    check("R10 no ovf flag", irq_ovf_o, 0);

    // overflow irq, count is 10
    wr_mode(8'h40);
    pulses(245);
    check("R3 count 255", count_o, 255);
    check("R10 before wrap", irq_ovf_o, 0);
    pulses(1);
    check("R4 wrap count", count_o, 0);
    check("R10 irq ovf", irq_ovf_o, 1);
    gie_i = 1'b0;
    @(negedge clk_i);
    check("R10 gie off", irq_ovf_o, 0);
    gie_i = 1'b1;
    wr_mask(8'h02);
    check("R8 bit0 is ovf mask", irq_ovf_o, 0);

    // reset mid-run
    do_reset();
    @(negedge clk_i);
    check("R1 count after run", count_o, 0);
    check("R1 flags after run", {cmp_flag_o, ovf_flag_o}, 0);
    check("R1 masks after run", {irq_cmp_o, irq_ovf_o}, 0);

    // low mode bits ignored
    cmp_val_i = 16'hFFFF;
    wr_mode(8'h3F);
    pulses(300);
    check("R3 low bits ignored", count_o, 300);
    repeat (5) @(negedge clk_i);
    check("R2 hold", count_o, 300);
    check("R4 no ovf", ovf_flag_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule